// File: doc/BRIEF.md
# Fully-Associative Translation Buffer with LRU Replacement

This block caches virtual-page-to-physical-frame translations. A lookup compares the presented virtual page number against every stored entry at once. Within the same cycle it returns a hit flag and the matching frame number, or it reports a miss. After the page table has been walked, the resolved translation is written in through the fill port.

The number of entries is tied to the page table: it is one quarter of the page-table entry count. The default is 128 page-table entries, which gives 32 buffer entries. A fill chooses its slot in this order:

1. An entry that already holds the same page.
2. Otherwise, the lowest-numbered empty entry.
3. Otherwise, the entry used least recently.

A frame-number invalidate input drops every translation that points at a reclaimed frame. Two free-running counters record how many lookups hit and how many missed.

Top module: `tlb_fa_lru`

## Requirements
- R1: When `lk_valid` is high and a valid entry holds `lk_vpn`, `lk_hit` is 1 and `lk_pfn` carries that entry's frame in the same cycle, with no clock edge in between. Otherwise `lk_hit` is 0 and `lk_pfn` is 0.
- R2: The buffer holds `PT_ENTRIES/4` entries, and every one of them can be found by a lookup.
- R3: After reset, no entry is valid, both counters are 0, and every lookup misses.
- R4: A fill whose page is not present, issued while some entry is empty, writes the empty entry with the lowest index.
- R5: A fill whose page is not present, issued while all entries are valid, replaces the least recently used entry.
- R6: A lookup hit or a fill makes the touched entry the most recently used, effective at the next edge. A lookup miss leaves the recency order unchanged.
- R7: An `inv_valid` pulse clears, at the next edge, every valid entry whose frame equals `inv_pfn`. Entries mapping other frames are not affected.
- R8: Each cycle with `lk_valid` high adds 1 to exactly one counter at the next edge: `hit_count` on a hit, `miss_count` on a miss.
- R9: A fill whose page is already present rewrites that entry's frame in place, so no page is ever held twice.
- R10: When several operations fall in the same cycle:
  - A fill decides the recency update over a concurrent lookup hit.
  - A fill's slot is chosen from the valid set as it stood before a concurrent invalidate.
  - The filled entry ends up valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_pfn | output | PFN_W | Frame number of the hit, 0 on miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| inv_valid | input | 1 | Drop translations of a frame |
| inv_pfn | input | PFN_W | Frame being reclaimed |
| hit_count | output | CNT_W | Number of lookups that hit |
| miss_count | output | CNT_W | Number of lookups that missed |

## Verification
The hit flag and the frame number are due in the same cycle as the lookup. Counters, recency order and entry contents change at the following rising edge. The bench drives inputs just after a falling edge and waits a few nanoseconds for the combinational result. It then compares the outputs against a queue-based model, which represents the state left by all earlier edges. Only after the next rising edge does it apply the stimulus to the model. This keeps every comparison one register stage behind each update.

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru #(
  parameter int PT_ENTRIES = 128,
  parameter int PFN_W      = 3,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             inv_valid,
  input  logic [PFN_W-1:0] inv_pfn,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int VPN_W = $clog2(PT_ENTRIES);
  localparam int N     = PT_ENTRIES / 4;
  localparam int AW    = $clog2(N);

  logic [N-1:0]       valid;
  logic [VPN_W-1:0]   tag   [N];
  logic [PFN_W-1:0]   frame [N];
  logic [AW-1:0]      age   [N];
  logic [N-1:0]       match, fmatch;
  logic [AW-1:0]      hit_idx, slot, touch_idx;
  logic               touch_en;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g]  = valid[g] && tag[g] == lk_vpn;
    assign fmatch[g] = valid[g] && tag[g] == fill_vpn;
  end

  assign lk_hit = lk_valid && |match;

  always_comb begin
    lk_pfn  = '0;
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) begin
        lk_pfn  = lk_valid ? frame[i] : '0;
        hit_idx = AW'(i);
      end
  end

  always_comb begin
    slot = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == AW'(N - 1)) slot = AW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) slot = AW'(i);
    for (int i = 0; i < N; i++)
      if (fmatch[i]) slot = AW'(i);
  end

  assign touch_en  = fill_valid || lk_hit;
  assign touch_idx = fill_valid ? slot : hit_idx;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        tag[g]   <= '0;
        frame[g] <= '0;
        age[g]   <= AW'(g);
      end else begin
        if (inv_valid && valid[g] && frame[g] == inv_pfn) valid[g] <= 1'b0;
        if (fill_valid && slot == AW'(g)) begin
          valid[g] <= 1'b1;
          tag[g]   <= fill_vpn;
          frame[g] <= fill_pfn;
        end
        if (touch_en) begin
          if (touch_idx == AW'(g))            age[g] <= '0;
          else if (age[g] < age[touch_idx])   age[g] <= age[g] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (lk_valid) begin
      if (lk_hit) hit_count  <= hit_count + 1'b1;
      else        miss_count <= miss_count + 1'b1;
    end
  end

  p_unique_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (hit_count + miss_count) == ($past(hit_count) + $past(miss_count) + 1'b1));

  p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid[$past(slot)] && tag[$past(slot)] == $past(fill_vpn)
                   && frame[$past(slot)] == $past(fill_pfn));

  p_fill_mru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> age[$past(slot)] == '0);

  p_idle_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(hit_count) && $stable(miss_count));
endmodule

// File: tb/tlb_fa_lru_test.sv
module tlb_fa_lru_test;
  localparam int PT = 128, N = PT / 4, VW = 7, PW = 3, CW = 16;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_valid = 0, inv_valid = 0;
  logic [VW-1:0] lk_vpn = 0, fill_vpn = 0;
  logic [PW-1:0] fill_pfn = 0, inv_pfn = 0, lk_pfn;
  logic lk_hit;
  logic [CW-1:0] hit_count, miss_count;

  always #10 clk = ~clk;

  tlb_fa_lru #(.PT_ENTRIES(PT), .PFN_W(PW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .inv_valid(inv_valid),
    .inv_pfn(inv_pfn), .hit_count(hit_count), .miss_count(miss_count));

  bit mv [N];
  int mt [N];
  int mf [N];
  int order[$];
  int mh = 0, mm = 0, vectors = 0, fails = 0;

  function automatic int find(int vpn);
    for (int i = 0; i < N; i++) if (mv[i] && mt[i] == vpn) return i;
    return -1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit lv, int vpn, bit fv, int fvpn, int fpfn,
                      bit iv, int ipfn, string req);
    int h, s, t;
    @(negedge clk);
    lk_valid = lv; lk_vpn = VW'(vpn);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_pfn = PW'(fpfn);
    inv_valid = iv; inv_pfn = PW'(ipfn);
    #3;
    h = lv ? find(vpn) : -1;
    check(req, "lk_hit", int'(lk_hit), int'(h >= 0));
    check(req, "lk_pfn", int'(lk_pfn), h >= 0 ? mf[h] : 0);
    check("R8", "hit_count", int'(hit_count), mh);
    check("R8", "miss_count", int'(miss_count), mm);
    @(posedge clk);
    if (lv) begin if (h >= 0) mh++; else mm++; end
    s = find(fvpn);
    if (s < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) s = i;
      if (s < 0) s = order[$];
    end
    if (iv) for (int i = 0; i < N; i++) if (mv[i] && mf[i] == ipfn) mv[i] = 0;
    if (fv) begin mv[s] = 1; mt[s] = fvpn; mf[s] = fpfn; end
    t = fv ? s : h;
    if (t >= 0) begin
      for (int k = 0; k < order.size(); k++)
        if (order[k] == t) begin order.delete(k); break; end
      order.push_front(t);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; order.push_back(i); end
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R3: empty after reset
    for (int v = 0; v < 4; v++) step(1, v * 9, 0, 0, 0, 0, 0, "R3");
    // R4, R2: fill every entry, lowest empty first
    for (int i = 0; i < N; i++) step(0, 0, 1, i + 40, i % 8, 0, 0, "R4");
    // R1, R2: each entry visible combinationally
    for (int i = 0; i < N; i++) step(1, i + 40, 0, 0, 0, 0, 0, "R1");
    // R6: misses leave the order intact, hits reorder
    step(1, 5, 0, 0, 0, 0, 0, "R6");
    step(1, 40, 0, 0, 0, 0, 0, "R6");
    // R5: full buffer evicts least recent
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, i, 7 - i, 0, 0, "R5");
      step(1, 41 + i, 0, 0, 0, 0, 0, "R5");
      step(1, i, 0, 0, 0, 0, 0, "R5");
    end
    // R9: refill existing page in place
    step(0, 0, 1, 50, 6, 0, 0, "R9");
    step(1, 50, 0, 0, 0, 0, 0, "R9");
    // R7: reclaim a frame
    step(0, 0, 0, 0, 0, 1, 3, "R7");
    for (int i = 0; i < N; i++) step(1, i + 40, 0, 0, 0, 0, 0, "R7");
    // R4: freed slots reused lowest first
    for (int i = 0; i < 6; i++) step(1, 90 + i, 1, 90 + i, i, 0, 0, "R4");
    // R10: mixed concurrent traffic
    for (int n = 0; n < 3000; n++)
      step($urandom % 2 == 1, 40 + $urandom % 60, $urandom % 3 == 0, 40 + $urandom % 60,
           $urandom % 8, $urandom % 11 == 0, $urandom % 8, "R10");
    summary();
  end
endmodule